// File: doc/BRIEF.md
# Graphics Command Queue with Packed Status

This block is a small first-in first-out buffer of 16-bit command words. It sits between a processor's peripheral register port and a graphics command engine. The processor loads a word by writing to either of two command register slots, a low one and a high one. The engine takes words off the head with a one-cycle take strobe and always sees the oldest stored word on its data output.

The block reports how many words it holds and how many slots are free, along with full and empty flags. It raises a one-cycle event when a take leaves it empty and another when a load is refused because it is full. While the enable input is low the queue is kept flushed. A packed 16-bit status word combines the queue state with an external DMA-activity input into one busy indication. A small read selector returns this word on a status read and zero on a read of either command slot. Address decoding happens outside the block.

Top module: `cmdq_top`

## Requirements
- R1: While enabled and not full, a cycle with `wr_lo_i` or `wr_hi_i` high (or both) stores one copy of `wdata_i`. Words leave in the order they were stored, and `head_o` always shows the oldest stored word.
- R2: While enabled, `take_i` removes the head word when the queue is not empty. A take on an empty queue is ignored and leaves the counts unchanged.
- R3: A load and a take in the same cycle on a queue that is neither empty nor full leave the used count unchanged. On a full queue, the same pair removes the head and drops the loaded word.
- R4: `used_o + free_o` always equals 8. `full_o` is high exactly when 8 words are held, `empty_o` is high exactly when 0 are held, and `avail_o` is the inverse of `empty_o`.
- R5: `drained_o` is high for exactly one cycle, in the cycle after the clock edge where a take without a simultaneous load removed the last word.
- R6: `ovfl_o` is high for exactly one cycle, in the cycle after the edge where a load was attempted on a full enabled queue. That word is dropped.
- R7: While `en_i` is low the queue is flushed: at the next edge the used count becomes 0, loads and takes are ignored, and no event is raised.
- R8: `busy_o` is high when the queue is not empty or `dma_busy_i` is high.
- R9: `status_o` is packed as: bit 15 busy, bits 14:13 zero, bit 12 `dma_busy_i`, bits 11:10 zero, bit 9 full, bit 8 empty, bits 7:4 used count, bits 3:0 free count.
- R10: `rdata_o` equals `status_o` when `rd_sel_i` is 2'b11 (status read). It is zero for 2'b01 and 2'b10 (low and high command slot reads) and for 2'b00 (no read).
- R11: After reset the queue is empty: used 0, free 8, empty high, full low, and both events low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Queue enable; low holds the queue flushed |
| wr_lo_i | input | 1 | Write strobe, low command slot |
| wr_hi_i | input | 1 | Write strobe, high command slot |
| wdata_i | input | 16 | Word written by the processor |
| take_i | input | 1 | Engine take strobe |
| dma_busy_i | input | 1 | External DMA activity |
| rd_sel_i | input | 2 | Read selector: 00 none, 01 cmd low, 10 cmd high, 11 status |
| head_o | output | 16 | Oldest stored word |
| avail_o | output | 1 | Queue holds at least one word |
| used_o | output | 4 | Words held |
| free_o | output | 4 | Free slots |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| drained_o | output | 1 | One-cycle event: a take emptied the queue |
| ovfl_o | output | 1 | One-cycle event: a load was refused because the queue was full |
| busy_o | output | 1 | Queue not empty or DMA active |
| status_o | output | 16 | Packed status word |
| rdata_o | output | 16 | Register read data |

## Verification
A load and a take can arrive in the same cycle. The interesting cases are on a full queue, where the take is honoured and the load overflows, and on a queue holding one word, where the take empties it but the load refills it, so no drained event may appear. The bench provokes both cases directly, then runs long random stretches where loads, takes, enable drops and DMA activity overlap. A queue-based reference model decides the outcome of every cycle, and every output is compared after each edge.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef struct packed {
    logic       busy;
    logic [1:0] rsv_hi;
    logic       dma;
    logic [1:0] rsv_lo;
    logic       full;
    logic       empty;
    logic [3:0] used;
    logic [3:0] free;
  } cmdq_stat_t;

  localparam logic [1:0] RdNone  = 2'b00;
  localparam logic [1:0] RdCmdLo = 2'b01;
  localparam logic [1:0] RdCmdHi = 2'b10;
  localparam logic [1:0] RdStat  = 2'b11;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [DW-1:0] mem_q [DEPTH];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[g] <= '0;
      else if (push_i && !flush_i && wr_ptr_q == AW'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign head_o = mem_q[rd_ptr_q];

  // R1
  word_landed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |=> mem_q[$past(wr_ptr_q)] == $past(wdata_i));
endmodule

// File: rtl/cmdq_level.sv
module cmdq_level #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [CW-1:0] used_o,
  output logic [CW-1:0] free_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drained_o,
  output logic          ovfl_o
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          drained_q, ovfl_q;

  assign full_o    = (cnt_q == CAP);
  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = en_i && push_req_i && !full_o;
  assign pop_ok_o  = en_i && pop_req_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      drained_q <= 1'b0;
      ovfl_q    <= 1'b0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      drained_q <= 1'b0;
      ovfl_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_q + CW'(push_ok_o) - CW'(pop_ok_o);
      drained_q <= pop_ok_o && !push_ok_o && (cnt_q == CW'(1));
      ovfl_q    <= push_req_i && full_o;
    end
  end

  assign used_o    = cnt_q;
  assign free_o    = CAP - cnt_q;
  assign drained_o = drained_q;
  assign ovfl_o    = ovfl_q;

  // R2
  idle_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_req_i && !push_req_i) |=> empty_o);
  // R3
  pair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && push_req_i && pop_req_i && !full_o && !empty_o) |=> $stable(cnt_q));
  // R5
  drained_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> (empty_o && $past(pop_req_i) && $past(en_i)));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovfl_o |-> ($past(full_o) && $past(push_req_i)));
  // R7
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (empty_o && !drained_o && !ovfl_o));
endmodule

// File: rtl/cmdq_top.sv
module cmdq_top
  import cmdq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [15:0]   wdata_i,
  input  logic          take_i,
  input  logic          dma_busy_i,
  input  logic [1:0]    rd_sel_i,
  output logic [15:0]   head_o,
  output logic          avail_o,
  output logic [CW-1:0] used_o,
  output logic [CW-1:0] free_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drained_o,
  output logic          ovfl_o,
  output logic          busy_o,
  output logic [15:0]   status_o,
  output logic [15:0]   rdata_o
);
  logic       push_ok, pop_ok;
  cmdq_stat_t stat;

  cmdq_level #(.DEPTH(DEPTH), .CW(CW)) i_level (
    .clk_i, .rst_ni, .en_i,
    .push_req_i (wr_lo_i | wr_hi_i),
    .pop_req_i  (take_i),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .used_o, .free_o, .full_o, .empty_o, .drained_o, .ovfl_o
  );

  cmdq_store #(.DW(16), .DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni,
    .flush_i (!en_i),
    .push_i  (push_ok),
    .pop_i   (pop_ok),
    .wdata_i,
    .head_o
  );

  assign avail_o = !empty_o;
  assign busy_o  = !empty_o || dma_busy_i;

  always_comb begin
    stat        = '0;
    stat.busy   = busy_o;
    stat.dma    = dma_busy_i;
    stat.full   = full_o;
    stat.empty  = empty_o;
    stat.used   = 4'(used_o);
    stat.free   = 4'(free_o);
  end
  assign status_o = stat;

  // command slots read back as zero; only the status slot returns data
  assign rdata_o = (rd_sel_i == RdStat) ? status_o : '0;

  // R4
  level_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(used_o) + 32'(free_o)) == DEPTH);
  // R8
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o || dma_busy_i) |-> status_o[15]);
  // R10
  cmd_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == RdCmdLo || rd_sel_i == RdCmdHi) |-> rdata_o == '0);
endmodule

// File: tb/test_cmdq_top.sv
module test_cmdq_top;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en, wr_lo, wr_hi, take, dma;
  logic [1:0] rd_sel;
  logic [15:0] wdata;
  logic [15:0] head, status, rdata;
  logic avail, full, empty, drained, ovfl, busy;
  logic [3:0] used, free;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [15:0] q[$];
  bit exp_dr = 0, exp_ov = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_top i_cmdq_top (
    .clk_i(clk), .rst_ni, .en_i(en), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(wdata), .take_i(take), .dma_busy_i(dma), .rd_sel_i(rd_sel),
    .head_o(head), .avail_o(avail), .used_o(used), .free_o(free),
    .full_o(full), .empty_o(empty), .drained_o(drained), .ovfl_o(ovfl),
    .busy_o(busy), .status_o(status), .rdata_o(rdata)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    int sz = q.size();
    logic e_full = (sz == CAP), e_empty = (sz == 0);
    logic e_busy = !e_empty || dma;
    logic [15:0] e_stat = {e_busy, 2'b00, dma, 2'b00, e_full, e_empty, 4'(sz), 4'(CAP - sz)};
    chk("R4 used", 16'(used), 16'(sz));
    chk("R4 free", 16'(free), 16'(CAP - sz));
    chk("R4 full", 16'(full), 16'(e_full));
    chk("R4 empty", 16'(empty), 16'(e_empty));
    chk("R4 avail", 16'(avail), 16'(!e_empty));
    chk("R5 drained", 16'(drained), 16'(exp_dr));
    chk("R6 overflow", 16'(ovfl), 16'(exp_ov));
    chk("R8 busy", 16'(busy), 16'(e_busy));
    chk("R9 status", status, e_stat);
    chk("R10 rdata", rdata, (rd_sel == 2'b11) ? e_stat : 16'h0);
    if (!e_empty) chk("R1 head", head, q[0]);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit lo, bit hi, bit tk, bit e, bit d, logic [1:0] sel, logic [15:0] w);
    bit pr, pok, tok;
    int sz;
    wr_lo = lo; wr_hi = hi; take = tk; en = e; dma = d; rd_sel = sel; wdata = w;
    @(posedge clk);
    sz = q.size();
    if (!e) begin
      q.delete(); exp_dr = 0; exp_ov = 0;
    end else begin
      pr  = lo || hi;
      pok = pr && sz < CAP;
      tok = tk && sz > 0;
      exp_ov = pr && sz == CAP;
      exp_dr = tok && !pok && sz == 1;
      if (tok) void'(q.pop_front());
      if (pok) q.push_back(w);
    end
    @(negedge clk);
    cyc++;
    check_all();
  endtask

  initial begin
    en = 1; wr_lo = 0; wr_hi = 0; take = 0; dma = 0; rd_sel = 2'b11; wdata = '0;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 used", 16'(used), 16'd0);
    chk("R11 free", 16'(free), 16'd8);
    chk("R11 empty", 16'(empty), 16'd1);
    chk("R11 full", 16'(full), 16'd0);
    chk("R11 events", {drained, ovfl}, 16'd0);
    rst_ni = 1'b1;
    // R2 take on empty
    step(0, 0, 1, 1, 0, 2'b11, 16'h0);
    // R1 fill through both slots, both strobes together counts once
    for (int i = 0; i < 7; i++) step(i[0], !i[0], 0, 1, 0, 2'b11, 16'h1000 + 16'(i));
    step(1, 1, 0, 1, 0, 2'b11, 16'h1007);
    // R6 load on full
    step(1, 0, 0, 1, 1, 2'b11, 16'hDEAD);
    step(0, 0, 0, 1, 1, 2'b01, 16'h0);
    // R3 load+take on full
    step(0, 1, 1, 1, 0, 2'b11, 16'hBEEF);
    // R10 command reads
    step(0, 0, 0, 1, 0, 2'b10, 16'h0);
    // R3 pair mid-level
    step(1, 0, 1, 1, 0, 2'b11, 16'h2222);
    // R5 drain down to empty, then extra take
    while (q.size() > 0) step(0, 0, 1, 1, 0, 2'b11, 16'h0);
    step(0, 0, 1, 1, 0, 2'b11, 16'h0);
    // R5 one word, pair must not raise drained
    step(1, 0, 0, 1, 0, 2'b11, 16'h3333);
    step(1, 0, 1, 1, 0, 2'b11, 16'h4444);
    step(0, 0, 1, 1, 0, 2'b11, 16'h0);
    // R7 flush with load attempts
    step(1, 0, 0, 1, 0, 2'b11, 16'h5555);
    step(1, 0, 0, 1, 0, 2'b11, 16'h6666);
    step(1, 1, 1, 0, 1, 2'b11, 16'h7777);
    step(0, 0, 0, 1, 0, 2'b11, 16'h0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 45, r > 90, ($urandom_range(0, 99) < 40), ($urandom_range(0, 99) > 3),
           $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), 16'($urandom()));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule